// File: doc/BRIEF.md
# Vectored Interrupt Priority and Acceptance Core

This block is the part of a processor-local interrupt controller that decides which interrupt the processor sees. It holds three per-vector bit arrays (requested, in-service and trigger-mode), each `NUM_VEC` bits wide and split into `WORD_W`-bit words. Sources post vectors into the requested array and flag each one as edge or level. Software sets a task priority and a spurious-vector register. The processor acknowledges interrupts and signals end of interrupt.

Each cycle the core works out the processor priority from the task priority and the highest in-service vector. It then sets its acceptance state machine to one of four states:
- `ACC_OFF`: software enable clear.
- `ACC_IDLE`: nothing requested.
- `ACC_HELD`: the best request is masked by priority.
- `ACC_PEND`: the best request may be taken.

The machine moves between any two of these states whenever the arrays or registers change. Each transition is named after its cause: disable, enable, drain, post, mask and unmask. Only `ACC_PEND` raises the pending output.

An acknowledge returns one of three results: the winning vector in `ACC_PEND`, the programmed spurious vector in `ACC_HELD`, or a "none" indication otherwise. End of interrupt retires the highest in-service vector. For a level-triggered vector it can also send a broadcast pulse to an I/O interrupt controller.

Top module: `vec_prio_core`

## Requirements
- R1: After reset all three arrays are empty, the task priority is 0 and the spurious-vector register is 0. `irq_pending`, `ppr`, `ack_rsp_valid` and `eoi_bc_valid` are all 0.
- R2: A request sets the requested bit of `req_vec`. It also writes `req_level` into that vector's trigger-mode bit: 1 means level, and 0 (edge) clears a bit a previous level request set.
- R3: The winning vector of an array is its highest set bit index, searched across all words. It is reported on `irq_vector` while `irq_pending` is 1.
- R4: The class of a vector is its upper 4 bits. `ppr` equals the task priority when the task-priority class is greater than or equal to the class of the highest in-service vector. Otherwise `ppr` equals that in-service class followed by four zero bits. An empty in-service array counts as class 0.
- R5: `irq_pending` is 1 only when the software-enable bit (bit 8 of the spurious-vector register) is set and the requested array is non-empty.
- R6: When `ppr` is non-zero and the class of the winning request is less than or equal to the class of `ppr`, the request is held: `irq_pending` is 0.
- R7: An acknowledge while pending responds with the winning vector (`ack_rsp_none`=0). In the same step it clears that vector's requested bit and sets its in-service bit.
- R8: An acknowledge while held responds with bits 7:0 of the spurious-vector register. An acknowledge while disabled or with nothing requested responds with `ack_rsp_none`=1.
- R9: End of interrupt clears the highest in-service bit. It pulses `eoi_bc_valid` with that vector on `eoi_bc_vec` only if the vector's trigger-mode bit is 1 and the directed-EOI flag (bit 12 of the spurious-vector register) is 0.
- R10: End of interrupt with an empty in-service array changes nothing and sends no broadcast.
- R11: A spurious-vector write keeps bits 8:0 and bit 12. Bits 15:13 and 11:9 are dropped.
- R12: A request and an acknowledge of the same vector in the same cycle leave that vector's requested bit set, and the vector also becomes in service.
- R13: `irq_pending`, `irq_vector`, `ppr` and both response outputs are registered. They reflect an operation after the same clock edge that captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Post a vector request |
| req_vec | input | 8 | Requested vector |
| req_level | input | 1 | 1 = level-triggered, 0 = edge-triggered |
| tpr_we | input | 1 | Task-priority write strobe |
| tpr_wdata | input | 8 | Task-priority write data |
| svr_we | input | 1 | Spurious-vector register write strobe |
| svr_wdata | input | 16 | Spurious-vector register write data |
| ack | input | 1 | Processor acknowledge strobe |
| eoi | input | 1 | End-of-interrupt strobe |
| irq_pending | output | 1 | An interrupt may be taken |
| irq_vector | output | 8 | Winning requested vector |
| ppr | output | 8 | Processor priority |
| ack_rsp_valid | output | 1 | Acknowledge response pulse |
| ack_rsp_none | output | 1 | Acknowledge found nothing to deliver |
| ack_rsp_vec | output | 8 | Delivered or spurious vector |
| eoi_bc_valid | output | 1 | EOI broadcast pulse |
| eoi_bc_vec | output | 8 | Vector being broadcast |

## Verification
The hardest situation to reach is a request that stays held while an earlier vector is in service. The bench must then show that end of interrupt both releases it and correctly decides whether to broadcast. That decision depends on the trigger mode recorded at request time and on the directed-EOI flag. The table walk builds nested in-service vectors by acknowledging a low-class request, then a higher-class one. It retires them one at a time and watches `ppr` fall back and the held request reappear. Directed steps then rewrite a vector's trigger mode from level to edge before retiring it. They also post and acknowledge the same vector in one cycle, so that its requested bit must survive.

// File: rtl/vp_pkg.sv
package vp_pkg;

    // Acceptance state of the core
    typedef enum logic [1:0] {
        ACC_OFF  = 2'd0,
        ACC_IDLE = 2'd1,
        ACC_HELD = 2'd2,
        ACC_PEND = 2'd3
    } acc_state_t;

    // Offsets of the control flags above the vector field of the spurious register
    localparam int SVR_EN_OFS   = 0;
    localparam int SVR_DEOI_OFS = 4;
    localparam int SVR_PAD      = 8;

endpackage

// File: rtl/vp_hifind.sv
module vp_hifind #(
    parameter int NBITS  = 256,
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(NBITS),
    localparam int BIT_W = $clog2(WORD_W),
    localparam int NWORD = NBITS / WORD_W
) (
    input  logic [NBITS-1:0] bits,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    logic [NWORD-1:0]       w_any;
    logic [NWORD*BIT_W-1:0] w_idx;

    function automatic logic [BIT_W-1:0] top_bit(input logic [WORD_W-1:0] v);
        logic [BIT_W-1:0] r;
        r = '0;
        for (int b = 0; b < WORD_W; b++) begin
            if (v[b]) r = BIT_W'(b);
        end
        return r;
    endfunction

    for (genvar w = 0; w < NWORD; w++) begin : g_word
        assign w_any[w]                 = |bits[w*WORD_W +: WORD_W];
        assign w_idx[w*BIT_W +: BIT_W]  = top_bit(bits[w*WORD_W +: WORD_W]);
    end

    // Later (higher) words override earlier ones
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NWORD; w++) begin
            if (w_any[w]) begin
                found = 1'b1;
                idx   = IDX_W'(w * WORD_W) + IDX_W'(w_idx[w*BIT_W +: BIT_W]);
            end
        end
    end

endmodule

// File: rtl/vp_ppr.sv
module vp_ppr #(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic             isr_found,
    input  logic [VEC_W-1:0] isr_idx,
    output logic [VEC_W-1:0] ppr
);

    localparam int SUB_W = VEC_W - CLS_W;

    logic [CLS_W-1:0] tpr_cls;
    logic [CLS_W-1:0] isr_cls;

    assign tpr_cls = tpr[VEC_W-1 -: CLS_W];
    assign isr_cls = isr_found ? isr_idx[VEC_W-1 -: CLS_W] : '0;

    always_comb begin
        if (tpr_cls >= isr_cls) ppr = tpr;
        else                    ppr = {isr_cls, {SUB_W{1'b0}}};
    end

endmodule

// File: rtl/vp_accept.sv
module vp_accept
    import vp_pkg::*;
#(
    parameter int VEC_W = 8,
    parameter int CLS_W = 4
) (
    input  logic             sw_en,
    input  logic             irr_found,
    input  logic [VEC_W-1:0] irr_idx,
    input  logic [VEC_W-1:0] ppr,
    output acc_state_t       nxt
);

    logic masked;

    assign masked = (ppr != '0) &&
                    (irr_idx[VEC_W-1 -: CLS_W] <= ppr[VEC_W-1 -: CLS_W]);

    always_comb begin
        if (!sw_en)          nxt = ACC_OFF;   // disable
        else if (!irr_found) nxt = ACC_IDLE;  // drain
        else if (masked)     nxt = ACC_HELD;  // mask
        else                 nxt = ACC_PEND;  // post / unmask
    end

endmodule

// File: rtl/vec_prio_core.sv
module vec_prio_core
    import vp_pkg::*;
#(
    parameter int NUM_VEC = 256,
    parameter int WORD_W  = 32,
    parameter int CLS_W   = 4,
    localparam int VEC_W  = $clog2(NUM_VEC),
    localparam int SVR_W  = VEC_W + SVR_PAD
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [VEC_W-1:0] req_vec,
    input  logic             req_level,
    input  logic             tpr_we,
    input  logic [VEC_W-1:0] tpr_wdata,
    input  logic             svr_we,
    input  logic [SVR_W-1:0] svr_wdata,
    input  logic             ack,
    input  logic             eoi,
    output logic             irq_pending,
    output logic [VEC_W-1:0] irq_vector,
    output logic [VEC_W-1:0] ppr,
    output logic             ack_rsp_valid,
    output logic             ack_rsp_none,
    output logic [VEC_W-1:0] ack_rsp_vec,
    output logic             eoi_bc_valid,
    output logic [VEC_W-1:0] eoi_bc_vec
);

    localparam int EN_BIT   = VEC_W + SVR_EN_OFS;
    localparam int DEOI_BIT = VEC_W + SVR_DEOI_OFS;

    // Architectural state
    logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
    logic [VEC_W-1:0]   tpr_q, spv_q;
    logic               sw_en_q, deoi_q;
    acc_state_t         state_q;
    logic [VEC_W-1:0]   win_q, ppr_q;

    // Next-state values
    logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;
    logic [VEC_W-1:0]   tpr_d, spv_d;
    logic               sw_en_d, deoi_d;
    acc_state_t         state_d;
    logic [VEC_W-1:0]   ppr_d;

    logic               cur_isr_found;
    logic [VEC_W-1:0]   cur_isr_idx;
    logic               nxt_irr_found, nxt_isr_found;
    logic [VEC_W-1:0]   nxt_irr_idx, nxt_isr_idx;
    logic               ack_take, eoi_hit;
    logic               svr_unused;

    assign svr_unused = ^{svr_wdata[SVR_W-1:DEOI_BIT+1], svr_wdata[DEOI_BIT-1:EN_BIT+1]};

    // Highest in-service vector before this cycle's updates (EOI target)
    vp_hifind #(.NBITS(NUM_VEC), .WORD_W(WORD_W)) u_find_cur_isr (
        .bits (isr_q),
        .found(cur_isr_found),
        .idx  (cur_isr_idx)
    );

    assign ack_take = ack && (state_q == ACC_PEND);
    assign eoi_hit  = eoi && cur_isr_found;

    // Array and register updates; request set wins over acknowledge clear
    always_comb begin
        irr_d = irr_q;
        isr_d = isr_q;
        tmr_d = tmr_q;
        if (ack_take) irr_d[win_q] = 1'b0;
        if (req_valid) begin
            irr_d[req_vec] = 1'b1;
            tmr_d[req_vec] = req_level;
        end
        if (eoi_hit)  isr_d[cur_isr_idx] = 1'b0;
        if (ack_take) isr_d[win_q]       = 1'b1;
        tpr_d   = tpr_we ? tpr_wdata : tpr_q;
        spv_d   = svr_we ? svr_wdata[VEC_W-1:0] : spv_q;
        sw_en_d = svr_we ? svr_wdata[EN_BIT]    : sw_en_q;
        deoi_d  = svr_we ? svr_wdata[DEOI_BIT]  : deoi_q;
    end

    vp_hifind #(.NBITS(NUM_VEC), .WORD_W(WORD_W)) u_find_irr (
        .bits (irr_d),
        .found(nxt_irr_found),
        .idx  (nxt_irr_idx)
    );

    vp_hifind #(.NBITS(NUM_VEC), .WORD_W(WORD_W)) u_find_isr (
        .bits (isr_d),
        .found(nxt_isr_found),
        .idx  (nxt_isr_idx)
    );

    vp_ppr #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_ppr (
        .tpr      (tpr_d),
        .isr_found(nxt_isr_found),
        .isr_idx  (nxt_isr_idx),
        .ppr      (ppr_d)
    );

    vp_accept #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_accept (
        .sw_en    (sw_en_d),
        .irr_found(nxt_irr_found),
        .irr_idx  (nxt_irr_idx),
        .ppr      (ppr_d),
        .nxt      (state_d)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ACC_OFF;
        else        state_q <= state_d;
    end

    // Data registers and responses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irr_q         <= '0;
            isr_q         <= '0;
            tmr_q         <= '0;
            tpr_q         <= '0;
            spv_q         <= '0;
            sw_en_q       <= 1'b0;
            deoi_q        <= 1'b0;
            win_q         <= '0;
            ppr_q         <= '0;
            ack_rsp_valid <= 1'b0;
            ack_rsp_none  <= 1'b0;
            ack_rsp_vec   <= '0;
            eoi_bc_valid  <= 1'b0;
            eoi_bc_vec    <= '0;
        end else begin
            irr_q         <= irr_d;
            isr_q         <= isr_d;
            tmr_q         <= tmr_d;
            tpr_q         <= tpr_d;
            spv_q         <= spv_d;
            sw_en_q       <= sw_en_d;
            deoi_q        <= deoi_d;
            win_q         <= nxt_irr_idx;
            ppr_q         <= ppr_d;
            ack_rsp_valid <= ack;
            unique case (state_q)
                ACC_PEND: begin
                    ack_rsp_none <= 1'b0;
                    ack_rsp_vec  <= win_q;
                end
                ACC_HELD: begin
                    ack_rsp_none <= 1'b0;
                    ack_rsp_vec  <= spv_q;
                end
                ACC_OFF, ACC_IDLE: begin
                    ack_rsp_none <= ack;
                    ack_rsp_vec  <= '0;
                end
                default: begin
                    ack_rsp_none <= 1'b0;
                    ack_rsp_vec  <= '0;
                end
            endcase
            eoi_bc_valid  <= eoi_hit && tmr_q[cur_isr_idx] && !deoi_q;
            eoi_bc_vec    <= cur_isr_idx;
        end
    end

    assign irq_pending = (state_q == ACC_PEND);
    assign irq_vector  = win_q;
    assign ppr         = ppr_q;

    // ---------------- assertions ----------------
    assert_req_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (irr_q[$past(req_vec)] && (tmr_q[$past(req_vec)] == $past(req_level))));

    assert_pend_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> (sw_en_q && irr_q[irq_vector]));

    assert_pend_above_ppr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pending |-> ((ppr == '0) ||
                         (irq_vector[VEC_W-1 -: CLS_W] > ppr[VEC_W-1 -: CLS_W])));

    assert_ack_moves_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && irq_pending) |=> (isr_q[$past(irq_vector)] && !ack_rsp_none &&
                                  (ack_rsp_vec == $past(irq_vector))));

    assert_bc_follows_eoi_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_bc_valid |-> ($past(eoi) && !isr_q[eoi_bc_vec]));

    assert_eoi_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !cur_isr_found) |=> (!eoi_bc_valid && (isr_q == $past(isr_q) || $past(ack))));

endmodule

// File: tb/vec_prio_core_bench.sv
module vec_prio_core_bench;

    localparam logic [2:0] OP_REQ = 3'd0;
    localparam logic [2:0] OP_TPR = 3'd1;
    localparam logic [2:0] OP_SVR = 3'd2;
    localparam logic [2:0] OP_ACK = 3'd3;
    localparam logic [2:0] OP_EOI = 3'd4;

    typedef struct packed {
        logic [2:0]  op;
        logic [15:0] arg;
        logic        lvl;
        logic        pend;
        logic [7:0]  vec;
        logic [7:0]  ppr;
        logic        rv;
        logic        none;
        logic [7:0]  rvec;
    } step_t;

    localparam int NSTEP = 34;
    localparam step_t TBL [NSTEP] = '{
        '{OP_REQ, 16'h0045, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00},
        '{OP_SVR, 16'h01FF, 1'b0, 1'b1, 8'h45, 8'h00, 1'b0, 1'b0, 8'h00},
        '{OP_REQ, 16'h0062, 1'b1, 1'b1, 8'h62, 8'h00, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h60, 1'b1, 1'b0, 8'h62},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h60, 1'b1, 1'b0, 8'hFF},
        '{OP_REQ, 16'h0071, 1'b0, 1'b1, 8'h71, 8'h60, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h70, 1'b1, 1'b0, 8'h71},
        '{OP_EOI, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h60, 1'b0, 1'b0, 8'h00},
        '{OP_EOI, 16'h0000, 1'b0, 1'b1, 8'h45, 8'h00, 1'b1, 1'b0, 8'h62},
        '{OP_TPR, 16'h0050, 1'b0, 1'b0, 8'h00, 8'h50, 1'b0, 1'b0, 8'h00},
        '{OP_TPR, 16'h0040, 1'b0, 1'b0, 8'h00, 8'h40, 1'b0, 1'b0, 8'h00},
        '{OP_TPR, 16'h003F, 1'b0, 1'b1, 8'h45, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h40, 1'b1, 1'b0, 8'h45},
        '{OP_EOI, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_EOI, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b1, 1'b1, 8'h00},
        '{OP_REQ, 16'h0080, 1'b1, 1'b1, 8'h80, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_SVR, 16'h11FF, 1'b0, 1'b1, 8'h80, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0, 8'h80},
        '{OP_EOI, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_REQ, 16'h0080, 1'b1, 1'b1, 8'h80, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_SVR, 16'hEFFF, 1'b0, 1'b1, 8'h80, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h80, 1'b1, 1'b0, 8'h80},
        '{OP_EOI, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b1, 1'b0, 8'h80},
        '{OP_REQ, 16'h0090, 1'b1, 1'b1, 8'h90, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_REQ, 16'h0090, 1'b0, 1'b1, 8'h90, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_SVR, 16'h00AA, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h3F, 1'b1, 1'b1, 8'h00},
        '{OP_SVR, 16'h01AA, 1'b0, 1'b1, 8'h90, 8'h3F, 1'b0, 1'b0, 8'h00},
        '{OP_TPR, 16'h0095, 1'b0, 1'b0, 8'h00, 8'h95, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h95, 1'b1, 1'b0, 8'hAA},
        '{OP_TPR, 16'h0000, 1'b0, 1'b1, 8'h90, 8'h00, 1'b0, 1'b0, 8'h00},
        '{OP_ACK, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h90, 1'b1, 1'b0, 8'h90},
        '{OP_EOI, 16'h0000, 1'b0, 1'b0, 8'h00, 8'h00, 1'b0, 1'b0, 8'h00}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_level = 1'b0;
    logic [7:0]  req_vec = '0;
    logic        tpr_we = 1'b0;
    logic [7:0]  tpr_wdata = '0;
    logic        svr_we = 1'b0;
    logic [15:0] svr_wdata = '0;
    logic        ack = 1'b0, eoi = 1'b0;
    logic        irq_pending, ack_rsp_valid, ack_rsp_none, eoi_bc_valid;
    logic [7:0]  irq_vector, ppr, ack_rsp_vec, eoi_bc_vec;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vec_prio_core u_vec_prio_core (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_vec(req_vec), .req_level(req_level),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata),
        .svr_we(svr_we), .svr_wdata(svr_wdata),
        .ack(ack), .eoi(eoi),
        .irq_pending(irq_pending), .irq_vector(irq_vector), .ppr(ppr),
        .ack_rsp_valid(ack_rsp_valid), .ack_rsp_none(ack_rsp_none), .ack_rsp_vec(ack_rsp_vec),
        .eoi_bc_valid(eoi_bc_valid), .eoi_bc_vec(eoi_bc_vec)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one operation for one cycle; results are sampled at the following negedge
    task automatic drive(input logic [2:0] op, input logic [15:0] arg, input logic lvl,
                         input logic also_ack);
        @(negedge clk);
        req_valid = (op == OP_REQ);
        req_vec   = arg[7:0];
        req_level = lvl;
        tpr_we    = (op == OP_TPR);
        tpr_wdata = arg[7:0];
        svr_we    = (op == OP_SVR);
        svr_wdata = arg;
        ack       = (op == OP_ACK) || also_ack;
        eoi       = (op == OP_EOI);
        @(negedge clk);
        req_valid = 1'b0; tpr_we = 1'b0; svr_we = 1'b0; ack = 1'b0; eoi = 1'b0;
    endtask

    task automatic chk_state(input string tag, input logic p, input logic [7:0] v,
                             input logic [7:0] pp);
        chk({tag, " R5/R6 pending"}, 16'(irq_pending), 16'(p));
        if (p) chk({tag, " R3 vector"}, 16'(irq_vector), 16'(v));
        chk({tag, " R4 ppr"}, 16'(ppr), 16'(pp));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL R13 watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 pending", 16'(irq_pending), 16'h0);
        chk("R1 ppr", 16'(ppr), 16'h0);
        chk("R1 ack_rsp_valid", 16'(ack_rsp_valid), 16'h0);
        chk("R1 eoi_bc_valid", 16'(eoi_bc_valid), 16'h0);
        rst_n = 1'b1;

        // Table walk: R2..R11, R13
        for (int i = 0; i < NSTEP; i++) begin
            string tag;
            tag = $sformatf("step%0d", i);
            drive(TBL[i].op, TBL[i].arg, TBL[i].lvl, 1'b0);
            chk_state(tag, TBL[i].pend, TBL[i].vec, TBL[i].ppr);
            if (TBL[i].op == OP_ACK) begin
                chk({tag, " R13 ack valid"}, 16'(ack_rsp_valid), 16'h1);
                chk({tag, " R8 ack none"}, 16'(ack_rsp_none), 16'(TBL[i].none));
                if (!TBL[i].none) chk({tag, " R7/R8 ack vector"}, 16'(ack_rsp_vec), 16'(TBL[i].rvec));
            end else begin
                chk({tag, " R13 no ack rsp"}, 16'(ack_rsp_valid), 16'h0);
            end
            chk({tag, " R9/R10/R11 broadcast"}, 16'(eoi_bc_valid),
                16'((TBL[i].op == OP_EOI) && TBL[i].rv));
            if ((TBL[i].op == OP_EOI) && TBL[i].rv)
                chk({tag, " R9 broadcast vector"}, 16'(eoi_bc_vec), 16'(TBL[i].rvec));
        end

        // R12: request and acknowledge of the same vector in one cycle
        drive(OP_REQ, 16'h0090, 1'b0, 1'b0);
        chk_state("R12 setup", 1'b1, 8'h90, 8'h00);
        drive(OP_REQ, 16'h0090, 1'b0, 1'b1);
        chk("R12 ack vector", 16'(ack_rsp_vec), 16'h0090);
        chk_state("R12 held after take", 1'b0, 8'h00, 8'h90);
        drive(OP_EOI, 16'h0, 1'b0, 1'b0);
        chk("R12 edge no broadcast", 16'(eoi_bc_valid), 16'h0);
        chk_state("R12 request survived", 1'b1, 8'h90, 8'h00);
        drive(OP_ACK, 16'h0, 1'b0, 1'b0);
        drive(OP_EOI, 16'h0, 1'b0, 1'b0);
        chk_state("R12 drained", 1'b0, 8'h00, 8'h00);

        // R3: lowest vector and word boundaries
        drive(OP_REQ, 16'h0000, 1'b0, 1'b0);
        chk_state("R3 vector zero", 1'b1, 8'h00, 8'h00);
        drive(OP_REQ, 16'h001F, 1'b0, 1'b0);
        chk_state("R3 word0 top", 1'b1, 8'h1F, 8'h00);
        drive(OP_REQ, 16'h0020, 1'b0, 1'b0);
        chk_state("R3 word1 bottom", 1'b1, 8'h20, 8'h00);
        drive(OP_REQ, 16'h00FF, 1'b0, 1'b0);
        chk_state("R3 last vector", 1'b1, 8'hFF, 8'h00);

        // R1: reset mid-run clears arrays and registers
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset pending", 16'(irq_pending), 16'h0);
        rst_n = 1'b1;
        drive(OP_SVR, 16'h01FF, 1'b0, 1'b0);
        chk_state("R1 arrays cleared", 1'b0, 8'h00, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule